// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM model. On every rising clock edge it samples the chip select, the three strobes, clock enable, the address bus and the bank select. It turns them into a single command code and keeps, for each bank, whether the bank is open and which row it holds. It also stores the programmed mode (burst length, burst order, read latency, single-write option) and raises a one-cycle error flag whenever the sampled command breaks a sequencing rule.

The row-to-column delay and the precharge-to-activate delay are checked in whole clock edges, set by parameters. A read or write that asks for an automatic close leaves its bank busy for the programmed burst length and then closes it, whether or not chip select is held high in the meantime. Illegal commands are reported and do not change any state. Storage cells, the data bus and analog timing are not modelled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Each sampled command is reported on `cmd_o` after the edge that samples it, using these codes (pins cs_n,ras_n,cas_n,we_n): no-op 0 (0111), deselect 1 (cs_n=1), activate 2 (0011), read 3 (0101, addr[10]=0), read with auto-close 4 (0101, addr[10]=1), write 5 (0100, addr[10]=0), write with auto-close 6 (0100, addr[10]=1), close one bank 7 (0010, addr[10]=0), close all 8 (0010, addr[10]=1), burst stop 9 (0110), refresh 10 (0001), mode load 11 (0000).
- R2: With cs_n high the code is 1, no bank changes state, no error is raised, and a pending automatic close still completes.
- R3: An activate to an idle bank opens the bank chosen by `ba`, sets bit `ba` of `bank_active_o` and stores addr as its row in `open_row_o[ba*ADDR_W +: ADDR_W]`.
- R4: An activate to a bank that is open or closing raises the error and leaves the stored row unchanged.
- R5: A read or write to an idle bank raises the error.
- R6: A read or write fewer than T_RCD edges after the activate of the same bank raises the error; at exactly T_RCD edges it is accepted.
- R7: A single close (addr[10]=0) clears only bank `ba`; a close-all (addr[10]=1) clears every bank whatever `ba` holds.
- R8: An activate fewer than T_RP edges after its bank was closed raises the error and the bank stays idle; at T_RP edges it is accepted.
- R9: A read or write with addr[10]=1 keeps the bank open for N edges (N = burst length 1, 2, 4 or 8) and closes it on the N-th edge after the command; a single close, read or write to that bank meanwhile raises the error, and the request with full-page length raises the error and leaves the bank open.
- R10: A mode load takes burst length from addr[2:0] (000=1, 001=2, 010=4, 011=8, 111=full page), burst order from addr[3] (1 = interleaved), read latency from addr[6:4] (010 or 011) and single-write from addr[9]; any other length or latency code, nonzero addr[8:7], or full page with interleaved order raises the error and keeps the old mode.
- R11: Refresh or mode load while any bank is open or closing raises the error.
- R12: The error output is high for exactly the one cycle that follows each illegal command.
- R13: If `cke` was low at the previous edge, no command is accepted: the code is 12 and no state changes.
- R14: After reset all banks are idle, the error is low, the code is 0 and the mode reads length code 000, sequential, latency 010, single-write 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| addr | input | ADDR_W | Row, column flags and mode value |
| ba | input | BA_W | Bank select |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Illegal-command pulse |
| bank_active_o | output | NUM_BANKS | Bank open or closing, one bit per bank |
| open_row_o | output | NUM_BANKS*ADDR_W | Stored row per bank |
| burst_len_o | output | 3 | Burst length code |
| burst_type_o | output | 1 | 1 = interleaved order |
| cas_lat_o | output | 3 | Read latency code |
| single_write_o | output | 1 | Burst read with single write |

## Verification
The bench probes the delay windows on both sides of each limit: a column command one and two edges after activate must fail and one at three edges must pass, and the same holds for re-opening after a close. A tracker with an off-by-one counter would reject the legal case or accept the early one. The automatic close is checked edge by edge with chip select held high during the burst, so a design that cancelled it on deselect, or closed one edge early or late, shows the wrong active mask. Reserved mode codes and busy-bank refresh or mode load check that rejected commands leave mode and rows untouched, and a low clock enable must suppress an activate on the following edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_DESEL = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_RDA   = 4'd4,
        CMD_WR    = 4'd5,
        CMD_WRA   = 4'd6,
        CMD_PRE   = 4'd7,
        CMD_PREA  = 4'd8,
        CMD_BST   = 4'd9,
        CMD_REF   = 4'd10,
        CMD_MRS   = 4'd11,
        CMD_SUSP  = 4'd12
    } cmd_e;

    typedef enum logic [1:0] {
        BOP_NONE  = 2'd0,
        BOP_OPEN  = 2'd1,
        BOP_CLOSE = 2'd2,
        BOP_AUTO  = 2'd3
    } bank_op_e;

    typedef enum logic [1:0] {
        BST_IDLE = 2'd0,
        BST_OPEN = 2'd1,
        BST_AUTO = 2'd2
    } bank_st_e;

    typedef struct packed {
        logic       single_wr;
        logic [2:0] cas_lat;
        logic       interleave;
        logic [2:0] blen;
    } mode_t;

    localparam int         BEAT_W  = 3;
    localparam logic [2:0] BL_FULL = 3'b111;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cke_prev_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    input  logic a10_i,
    output cmd_e cmd_o
);
    always_comb begin
        cmd_o = CMD_NOP;
        if (!cke_prev_i) begin
            cmd_o = CMD_SUSP;
        end else if (cs_n_i) begin
            cmd_o = CMD_DESEL;
        end else begin
            case ({ras_n_i, cas_n_i, we_n_i})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = a10_i ? CMD_RDA : CMD_RD;
                3'b100:  cmd_o = a10_i ? CMD_WRA : CMD_WR;
                3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
                3'b110:  cmd_o = CMD_BST;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_MRS;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_mode.sv
module sdcmd_mode
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [9:0]        fld_i,
    output mode_t             mode_o,
    output logic              fld_ok_o,
    output logic [BEAT_W-1:0] beats_m1_o
);
    localparam mode_t MODE_RST = '{single_wr: 1'b0, cas_lat: 3'b010,
                                   interleave: 1'b0, blen: 3'b000};

    mode_t mode_d, mode_q;
    logic  bl_ok, cl_ok;

    always_comb begin
        bl_ok    = (fld_i[2:0] inside {3'b000, 3'b001, 3'b010, 3'b011, BL_FULL});
        cl_ok    = (fld_i[6:4] inside {3'b010, 3'b011});
        fld_ok_o = bl_ok && cl_ok && (fld_i[8:7] == 2'b00)
                   && !((fld_i[2:0] == BL_FULL) && fld_i[3]);

        mode_d = mode_q;
        if (wr_i) begin
            mode_d.blen       = fld_i[2:0];
            mode_d.interleave = fld_i[3];
            mode_d.cas_lat    = fld_i[6:4];
            mode_d.single_wr  = fld_i[9];
        end

        case (mode_q.blen)
            3'b000:  beats_m1_o = BEAT_W'(0);
            3'b001:  beats_m1_o = BEAT_W'(1);
            3'b010:  beats_m1_o = BEAT_W'(3);
            default: beats_m1_o = BEAT_W'(7);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RST;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    assert_latency_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.cas_lat == 3'b010) || (mode_q.cas_lat == 3'b011));

    assert_bad_code_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fld_ok_o) |=> $stable(mode_q));
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
    import sdcmd_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_op_e          op_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [BEAT_W-1:0] beats_m1_i,
    output logic              active_o,
    output logic              closing_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              rcd_met_o,
    output logic              rp_met_o
);
    localparam int TLIM  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TMR_W = $clog2(TLIM + 1);

    typedef struct packed {
        bank_st_e          st;
        logic [ROW_W-1:0]  row;
        logic [TMR_W-1:0]  tmr;
        logic [BEAT_W-1:0] cnt;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (bank_q.tmr != TMR_W'(TLIM)) bank_d.tmr = bank_q.tmr + 1'b1;
        case (op_i)
            BOP_OPEN: begin
                bank_d.st  = BST_OPEN;
                bank_d.row = row_i;
                bank_d.tmr = '0;
            end
            BOP_CLOSE: begin
                if (bank_q.st != BST_IDLE) begin
                    bank_d.st  = BST_IDLE;
                    bank_d.tmr = '0;
                end
            end
            BOP_AUTO: begin
                bank_d.st  = BST_AUTO;
                bank_d.cnt = beats_m1_i;
            end
            default: begin
                if (bank_q.st == BST_AUTO) begin
                    if (bank_q.cnt == '0) begin
                        bank_d.st  = BST_IDLE;
                        bank_d.tmr = '0;
                    end else begin
                        bank_d.cnt = bank_q.cnt - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.st  <= BST_IDLE;
            bank_q.row <= '0;
            bank_q.tmr <= TMR_W'(TLIM);
            bank_q.cnt <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active_o  = (bank_q.st != BST_IDLE);
    assign closing_o = (bank_q.st == BST_AUTO);
    assign row_o     = bank_q.row;
    assign rcd_met_o = (bank_q.st == BST_OPEN) && (bank_q.tmr >= TMR_W'(T_RCD - 1));
    assign rp_met_o  = (bank_q.st == BST_IDLE) && (bank_q.tmr >= TMR_W'(T_RP - 1));

    assert_open_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == BOP_OPEN) |-> (bank_q.st == BST_IDLE));

    assert_auto_finishes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.st == BST_AUTO && bank_q.cnt == '0 && op_i == BOP_NONE) |=> !active_o);

    assert_row_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != BOP_OPEN) |=> $stable(row_o));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic                        cke,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BA_W-1:0]             ba,
    output logic [3:0]                  cmd_o,
    output logic                        err_o,
    output logic [NUM_BANKS-1:0]        bank_active_o,
    output logic [NUM_BANKS*ADDR_W-1:0] open_row_o,
    output logic [2:0]                  burst_len_o,
    output logic                        burst_type_o,
    output logic [2:0]                  cas_lat_o,
    output logic                        single_write_o
);
    localparam int ROW_W = ADDR_W;

    typedef struct packed {
        cmd_e cmd;
        logic err;
        logic cke;
    } out_t;

    out_t              out_d, out_q;
    cmd_e              cmd_w;
    mode_t             mode_w;
    logic              fld_ok_w, mode_wr;
    logic [BEAT_W-1:0] beats_m1_w;
    bank_op_e          op [NUM_BANKS];
    logic [NUM_BANKS-1:0] act_w, closing_w, rcd_w, rp_w;
    logic [ROW_W-1:0]  row_w [NUM_BANKS];

    sdcmd_decode u_decode (
        .cke_prev_i (out_q.cke),
        .cs_n_i     (cs_n),
        .ras_n_i    (ras_n),
        .cas_n_i    (cas_n),
        .we_n_i     (we_n),
        .a10_i      (addr[10]),
        .cmd_o      (cmd_w)
    );

    sdcmd_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (mode_wr),
        .fld_i      (addr[9:0]),
        .mode_o     (mode_w),
        .fld_ok_o   (fld_ok_w),
        .beats_m1_o (beats_m1_w)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        sdcmd_bank #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .op_i       (op[gi]),
            .row_i      (addr[ROW_W-1:0]),
            .beats_m1_i (beats_m1_w),
            .active_o   (act_w[gi]),
            .closing_o  (closing_w[gi]),
            .row_o      (row_w[gi]),
            .rcd_met_o  (rcd_w[gi]),
            .rp_met_o   (rp_w[gi])
        );
        assign open_row_o[gi*ROW_W +: ROW_W] = row_w[gi];
    end

    always_comb begin
        out_d.cmd = cmd_w;
        out_d.err = 1'b0;
        out_d.cke = cke;
        mode_wr   = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) op[i] = BOP_NONE;

        case (cmd_w)
            CMD_ACT: begin
                if (act_w[ba] || !rp_w[ba]) out_d.err = 1'b1;
                else                        op[ba]    = BOP_OPEN;
            end
            CMD_RD, CMD_WR: begin
                if (!rcd_w[ba]) out_d.err = 1'b1;
            end
            CMD_RDA, CMD_WRA: begin
                if (!rcd_w[ba] || (mode_w.blen == BL_FULL)) out_d.err = 1'b1;
                else                                          op[ba]    = BOP_AUTO;
            end
            CMD_PRE: begin
                if (closing_w[ba]) out_d.err = 1'b1;
                else               op[ba]    = BOP_CLOSE;
            end
            CMD_PREA: begin
                if (|closing_w) out_d.err = 1'b1;
                else for (int i = 0; i < NUM_BANKS; i++) op[i] = BOP_CLOSE;
            end
            CMD_REF: begin
                if (|act_w) out_d.err = 1'b1;
            end
            CMD_MRS: begin
                if ((|act_w) || !fld_ok_w) out_d.err = 1'b1;
                else                       mode_wr   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.cmd <= CMD_NOP;
            out_q.err <= 1'b0;
            out_q.cke <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign cmd_o          = out_q.cmd;
    assign err_o          = out_q.err;
    assign bank_active_o  = act_w;
    assign burst_len_o    = mode_w.blen;
    assign burst_type_o   = mode_w.interleave;
    assign cas_lat_o      = mode_w.cas_lat;
    assign single_write_o = mode_w.single_wr;

    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.cke && cs_n) |=> (!err_o && cmd_o == CMD_DESEL));

    assert_mode_only_by_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w != CMD_MRS) |=> $stable({burst_len_o, burst_type_o, cas_lat_o, single_write_o}));

    assert_busy_maintenance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_w == CMD_REF || cmd_w == CMD_MRS) && (|act_w)) |=> err_o);

    assert_suspend_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q.cke) |=> (cmd_o == CMD_SUSP && !err_o));
endmodule

// File: tb/sdram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_bench;
    localparam logic [3:0] P_NOP = 4'b0111, P_DES = 4'b1000, P_ACT = 4'b0011,
                           P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                           P_BST = 4'b0110, P_REF = 4'b0001, P_MRS = 4'b0000;
    localparam logic [3:0] C_NOP = 0, C_DES = 1, C_ACT = 2, C_RD = 3, C_RDA = 4,
                           C_WR = 5, C_WRA = 6, C_PRE = 7, C_PREA = 8, C_BST = 9,
                           C_REF = 10, C_MRS = 11, C_SUSP = 12;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic [3:0]  cmd_o, bank_active_o;
    logic        err_o, burst_type_o, single_write_o;
    logic [51:0] open_row_o;
    logic [2:0]  burst_len_o, cas_lat_o;

    int nchk = 0, nerr = 0;

    always #2 clk = ~clk;

    sdram_cmd_tracker u_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .addr(addr), .ba(ba), .cmd_o(cmd_o), .err_o(err_o),
        .bank_active_o(bank_active_o), .open_row_o(open_row_o),
        .burst_len_o(burst_len_o), .burst_type_o(burst_type_o),
        .cas_lat_o(cas_lat_o), .single_write_o(single_write_o)
    );

    typedef struct packed {
        logic [3:0]  cmd;
        logic        err;
        logic [3:0]  act;
        logic        rchk;
        logic [1:0]  rbank;
        logic [12:0] rval;
        logic        mchk;
        logic [7:0]  mval;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    task automatic chk(input string tag, input string what, input int got, input int want);
        nchk++;
        if (got != want) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, want);
        end
    endtask

    task automatic step(input logic [3:0] p, input logic ck, input logic [12:0] a,
                        input logic [1:0] b, input logic [3:0] ecmd, input logic eerr,
                        input logic [3:0] eact, input string tag,
                        input logic rc = 1'b0, input logic [1:0] rb = 2'd0,
                        input logic [12:0] rv = 13'd0,
                        input logic mc = 1'b0, input logic [7:0] mv = 8'd0);
        exp_t e;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = p;
        cke  = ck;
        addr = a;
        ba   = b;
        e.cmd = ecmd; e.err = eerr; e.act = eact;
        e.rchk = rc; e.rbank = rb; e.rval = rv;
        e.mchk = mc; e.mval = mv;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // Monitor: compare each queued expectation just after the edge that samples it
    always @(posedge clk) begin
        #1;
        if (rst_n && expq.size() > 0) begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(t, "cmd", int'(cmd_o), int'(e.cmd));
            chk(t, "err", int'(err_o), int'(e.err));
            chk(t, "active", int'(bank_active_o), int'(e.act));
            if (e.rchk)
                chk(t, "row", int'(open_row_o[e.rbank*13 +: 13]), int'(e.rval));
            if (e.mchk)
                chk(t, "mode", int'({single_write_o, cas_lat_o, burst_type_o, burst_len_o}),
                    int'(e.mval));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R14 reset state
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0000, "R14", 0, 0, 0, 1, 8'h20);
        // R10 mode load and rejected codes
        step(P_MRS, 1, 13'h0232, 0, C_MRS, 0, 4'b0000, "R10", 0, 0, 0, 1, 8'hB2);
        step(P_MRS, 1, 13'h0035, 0, C_MRS, 1, 4'b0000, "R10", 0, 0, 0, 1, 8'hB2);
        step(P_MRS, 1, 13'h0012, 0, C_MRS, 1, 4'b0000, "R10", 0, 0, 0, 1, 8'hB2);
        step(P_MRS, 1, 13'h003F, 0, C_MRS, 1, 4'b0000, "R10", 0, 0, 0, 1, 8'hB2);
        // R3 open bank 1; R6 row-to-column window
        step(P_ACT, 1, 13'h1ABC, 1, C_ACT, 0, 4'b0010, "R3", 1, 1, 13'h1ABC);
        step(P_RD,  1, 13'h0000, 1, C_RD,  1, 4'b0010, "R6");
        step(P_RD,  1, 13'h0000, 1, C_RD,  1, 4'b0010, "R6");
        step(P_RD,  1, 13'h0000, 1, C_RD,  0, 4'b0010, "R6 R12");
        step(P_RD,  1, 13'h0000, 2, C_RD,  1, 4'b0010, "R5");
        step(P_ACT, 1, 13'h0F0F, 1, C_ACT, 1, 4'b0010, "R4", 1, 1, 13'h1ABC);
        step(P_MRS, 1, 13'h0020, 0, C_MRS, 1, 4'b0010, "R11", 0, 0, 0, 1, 8'hB2);
        step(P_REF, 1, 13'h0000, 0, C_REF, 1, 4'b0010, "R11");
        step(P_ACT, 1, 13'h0055, 3, C_ACT, 0, 4'b1010, "R3", 1, 3, 13'h0055);
        step(P_DES, 1, 13'h0000, 0, C_DES, 0, 4'b1010, "R2");
        // R7 single close, R8 re-open window
        step(P_PRE, 1, 13'h0000, 3, C_PRE, 0, 4'b0010, "R7");
        step(P_ACT, 1, 13'h0777, 3, C_ACT, 1, 4'b0010, "R8");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0010, "R1");
        step(P_ACT, 1, 13'h0777, 3, C_ACT, 0, 4'b1010, "R8", 1, 3, 13'h0777);
        step(P_PRE, 1, 13'h0400, 0, C_PREA, 0, 4'b0000, "R7");
        step(P_BST, 1, 13'h0000, 0, C_BST, 0, 4'b0000, "R1");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0000, "R1");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0000, "R1");
        // R9 read with auto-close, burst length 4, deselect during burst
        step(P_ACT, 1, 13'h0123, 0, C_ACT, 0, 4'b0001, "R3", 1, 0, 13'h0123);
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0001, "R1");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0001, "R1");
        step(P_RD,  1, 13'h0400, 0, C_RDA, 0, 4'b0001, "R9");
        step(P_DES, 1, 13'h0000, 0, C_DES, 0, 4'b0001, "R2 R9");
        step(P_PRE, 1, 13'h0000, 0, C_PRE, 1, 4'b0001, "R9");
        step(P_RD,  1, 13'h0000, 0, C_RD,  1, 4'b0001, "R9");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0000, "R9");
        // R13 clock enable low suppresses the next command
        step(P_NOP, 0, 13'h0000, 0, C_NOP,  0, 4'b0000, "R13");
        step(P_ACT, 1, 13'h0999, 2, C_SUSP, 0, 4'b0000, "R13");
        step(P_ACT, 1, 13'h0AAA, 2, C_ACT,  0, 4'b0100, "R13 R3", 1, 2, 13'h0AAA);
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0100, "R1");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0100, "R1");
        step(P_WR,  1, 13'h0400, 2, C_WRA, 0, 4'b0100, "R9");
        step(P_MRS, 1, 13'h0033, 0, C_MRS, 1, 4'b0100, "R11", 0, 0, 0, 1, 8'hB2);
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0100, "R9");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0100, "R9");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0000, "R9");
        // R10 full page, then R9 auto-close refused at full page
        step(P_MRS, 1, 13'h0037, 0, C_MRS, 0, 4'b0000, "R10", 0, 0, 0, 1, 8'h37);
        step(P_ACT, 1, 13'h0005, 1, C_ACT, 0, 4'b0010, "R3", 1, 1, 13'h0005);
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0010, "R1");
        step(P_NOP, 1, 13'h0000, 0, C_NOP, 0, 4'b0010, "R1");
        step(P_WR,  1, 13'h0400, 1, C_WRA, 1, 4'b0010, "R9");
        step(P_WR,  1, 13'h0000, 1, C_WR,  0, 4'b0010, "R1");
        step(P_PRE, 1, 13'h0400, 2, C_PREA, 0, 4'b0000, "R7");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule